// File: doc/BRIEF.md
# Active Miller Clamp Controller

This block sequences the three switches of one gate output stage: a pull-up that charges the gate, a main pull-down that discharges it, and an extra low-impedance clamp pull-down. The clamp holds the gate firmly off against current that the switch's collector-gate capacitance injects during fast voltage swings. The controller takes a drive command that an upstream noise filter has already cleaned. It also takes the output of a comparator that reports when the gate voltage is below the clamp threshold. From these it produces three enable signals. Both inputs are assumed to be synchronous to the block clock.

When the command rises, both pull-downs release. The pull-up then engages after a dead time of `DEAD_CYCLES` clock cycles with every switch off. When the command falls, the pull-up releases and the main pull-down follows after the same dead time. While the main pull-down is on and the command stays low, a below-threshold report from the comparator engages the clamp. Once engaged, the clamp rides through coupling spikes that lift the gate above the threshold. It lets go only after `FILT_CYCLES` consecutive above-threshold cycles, or when the command rises.

Top module: `miller_clamp_ctrl`

## Requirements
- R1: During and right after a synchronous active-low reset, the pull-up enable is 0, the main pull-down enable is 1 and the clamp enable is 0.
- R2: A high command sampled while the main pull-down is on turns the pull-up on `DEAD_CYCLES` + 1 clock edges later, and the pull-up then stays on while the command stays high.
- R3: A low command sampled while the pull-up is on turns the pull-up off at the next edge and turns the main pull-down on `DEAD_CYCLES` edges after that.
- R4: The pull-up enable is never 1 in a cycle where the main pull-down or the clamp enable is 1.
- R5: Every handover between the pull-up and the pull-downs passes through at least `DEAD_CYCLES` cycles in which all three enables are 0.
- R6: The clamp turns on at the edge after a cycle in which the main pull-down was already on, the command was low and the comparator reported below-threshold. It never turns on in any other case.
- R7: While the command stays low, an engaged clamp stays on through any run of fewer than `FILT_CYCLES` consecutive above-threshold cycles. A below-threshold cycle restarts the count.
- R8: With the command low, the clamp turns off at the edge that ends the `FILT_CYCLES`-th consecutive above-threshold cycle, and the main pull-down stays on. The clamp re-engages once the comparator reports below-threshold again.
- R9: A high command releases the clamp at the same edge at which the main pull-down turns off. This holds even when the comparator reports below-threshold in that cycle.
- R10: While the pull-up is on, the comparator input has no effect: the pull-up stays on and the clamp stays off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| drive_cmd | input | 1 | Filtered gate drive command, 1 = gate on |
| gate_low | input | 1 | Comparator output, 1 = gate voltage below clamp threshold |
| pu_en | output | 1 | Pull-up switch enable |
| pd_en | output | 1 | Main pull-down switch enable |
| clamp_en | output | 1 | Clamp pull-down switch enable |

## Verification
On every cycle the checker enforces the following. The pull-up never coexists with either pull-down, and each enable that falls is followed by a cycle with all enables off. The clamp only rises after a low-command, below-threshold cycle with the pull-down on. A checker-side counter of consecutive above-threshold cycles proves that the clamp holds through short excursions and drops only at the full filter length. The bench scenarios cover what needs a known stimulus history: the exact edges at which each enable moves after a command change, the reset values, and a filter count that restarts after an interrupted excursion. They also cover the clamp re-engaging after release, and the comparator being ignored while the gate is driven on.

// File: rtl/mc_pkg.sv
// Package: shared types of the active Miller clamp controller.
// Assumes nothing beyond SystemVerilog-2017 enums.
package mc_pkg;

    // Output-stage phase: which side of the stage may conduct.
    typedef enum logic [1:0] {
        PH_PULLDN = 2'd0,   // main pull-down conducting
        PH_GAP_UP = 2'd1,   // all off, heading to pull-up
        PH_PULLUP = 2'd2,   // pull-up conducting
        PH_GAP_DN = 2'd3    // all off, heading to pull-down
    } phase_t;

endpackage

// File: rtl/mc_phase_fsm.sv
// Module: mc_phase_fsm
// Sequences the output stage between pull-down and pull-up through a
// dead-time gap of DEAD_CYCLES cycles. A gap always runs to completion.
// Assumes: cmd is synchronous to clk and DEAD_CYCLES >= 1.
module mc_phase_fsm
    import mc_pkg::*;
#(
    parameter int DEAD_CYCLES = 1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cmd,
    output phase_t phase_q,
    output phase_t phase_d
);

    localparam int DW = (DEAD_CYCLES > 1) ? $clog2(DEAD_CYCLES) : 1;
    localparam logic [DW-1:0] GAP_LOAD = DW'(DEAD_CYCLES - 1);

    logic [DW-1:0] gap_cnt_q;
    logic [DW-1:0] gap_cnt_d;

    // Next-phase and gap-counter decision.
    always_comb begin
        phase_d   = phase_q;
        gap_cnt_d = gap_cnt_q;
        unique case (phase_q)
            PH_PULLDN: if (cmd) begin
                phase_d   = PH_GAP_UP;
                gap_cnt_d = GAP_LOAD;
            end
            PH_PULLUP: if (!cmd) begin
                phase_d   = PH_GAP_DN;
                gap_cnt_d = GAP_LOAD;
            end
            PH_GAP_UP: begin
                if (gap_cnt_q == '0) phase_d = PH_PULLUP;
                else                 gap_cnt_d = gap_cnt_q - 1'b1;
            end
            PH_GAP_DN: begin
                if (gap_cnt_q == '0) phase_d = PH_PULLDN;
                else                 gap_cnt_d = gap_cnt_q - 1'b1;
            end
            default: phase_d = PH_PULLDN;
        endcase
    end

    // Phase and gap-counter registers, reset into the pull-down phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_PULLDN;
            gap_cnt_q <= '0;
        end else begin
            phase_q   <= phase_d;
            gap_cnt_q <= gap_cnt_d;
        end
    end

endmodule

// File: rtl/mc_clamp_filter.sv
// Module: mc_clamp_filter
// Engages the clamp when armed and the gate is below threshold. It releases
// after FILT_CYCLES consecutive above-threshold cycles, or at once when the
// arm is withdrawn.
// Assumes: cmp_low is synchronous to clk and FILT_CYCLES >= 1.
module mc_clamp_filter #(
    parameter int FILT_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic cmp_low,
    output logic clamp_q
);

    localparam int FW = (FILT_CYCLES > 1) ? $clog2(FILT_CYCLES) : 1;
    localparam logic [FW-1:0] LAST_HIGH = FW'(FILT_CYCLES - 1);

    logic [FW-1:0] high_cnt_q;

    // Clamp state and consecutive above-threshold counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm) begin
            clamp_q    <= 1'b0;
            high_cnt_q <= '0;
        end else if (!clamp_q) begin
            clamp_q    <= cmp_low;
            high_cnt_q <= '0;
        end else if (cmp_low) begin
            high_cnt_q <= '0;
        end else if (high_cnt_q == LAST_HIGH) begin
            clamp_q    <= 1'b0;
            high_cnt_q <= '0;
        end else begin
            high_cnt_q <= high_cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/miller_clamp_ctrl.sv
// Module: miller_clamp_ctrl (top)
// Drives the pull-up, main pull-down and clamp pull-down enables of one gate
// output stage from a filtered command and a below-threshold comparator.
// Assumes: both inputs are synchronous to clk; reset is synchronous, active low.
module miller_clamp_ctrl
    import mc_pkg::*;
#(
    parameter int DEAD_CYCLES = 1,
    parameter int FILT_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drive_cmd,
    input  logic gate_low,
    output logic pu_en,
    output logic pd_en,
    output logic clamp_en
);

    phase_t phase_q;
    phase_t phase_d;
    logic   clamp_arm;

    mc_phase_fsm #(.DEAD_CYCLES(DEAD_CYCLES)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (drive_cmd),
        .phase_q (phase_q),
        .phase_d (phase_d)
    );

    // Clamp may act only while the pull-down is on now and stays on next.
    assign clamp_arm = (phase_q == PH_PULLDN) && (phase_d == PH_PULLDN);

    mc_clamp_filter #(.FILT_CYCLES(FILT_CYCLES)) u_clamp (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (clamp_arm),
        .cmp_low (gate_low),
        .clamp_q (clamp_en)
    );

    // Switch enables decoded from the registered phase.
    assign pu_en = (phase_q == PH_PULLUP);
    assign pd_en = (phase_q == PH_PULLDN);

endmodule

// File: rtl/miller_clamp_ctrl_sva.sv
// Module: miller_clamp_ctrl_sva
// Checker bound to miller_clamp_ctrl. Watches the ports only and keeps its
// own count of consecutive above-threshold cycles under an engaged clamp.
module miller_clamp_ctrl_sva #(
    parameter int FILT_CYCLES = 8
) (
    input logic clk,
    input logic rst_n,
    input logic drive_cmd,
    input logic gate_low,
    input logic pu_en,
    input logic pd_en,
    input logic clamp_en
);

    localparam int RW = $clog2(FILT_CYCLES + 2);
    localparam logic [RW-1:0] RUN_FULL = RW'(FILT_CYCLES);
    localparam logic [RW-1:0] RUN_HOLD = RW'(FILT_CYCLES - 1);

    logic [RW-1:0] run_q;

    // Consecutive cycles with the clamp on and the gate above threshold.
    always_ff @(posedge clk) begin
        if (!rst_n || !(clamp_en && !gate_low)) run_q <= '0;
        else if (run_q != RUN_FULL)             run_q <= run_q + 1'b1;
    end

    AST_PU_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        pu_en |-> (!pd_en && !clamp_en)); // R4

    AST_GAP_AFTER_PU: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pu_en) |-> (!pd_en && !clamp_en)); // R5

    AST_GAP_AFTER_PD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pd_en) |-> !pu_en); // R5

    AST_PU_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pu_en) |-> $past(!pd_en && !clamp_en)); // R2

    AST_CLAMP_NEEDS_PD: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_en |-> pd_en); // R6

    AST_CLAMP_ENGAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_en && !drive_cmd && gate_low) |=> clamp_en); // R6

    AST_CLAMP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clamp_en) |-> $past(pd_en && !drive_cmd && gate_low)); // R6

    AST_CLAMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (clamp_en && !drive_cmd && (gate_low || run_q < RUN_HOLD)) |=> clamp_en); // R7

    AST_CLAMP_RELEASE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(clamp_en) && !$past(drive_cmd)) |-> (run_q == RUN_FULL && pd_en)); // R8

    AST_CMD_DROPS_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (clamp_en && drive_cmd) |=> (!clamp_en && !pd_en)); // R9

endmodule

bind miller_clamp_ctrl miller_clamp_ctrl_sva #(.FILT_CYCLES(FILT_CYCLES)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .drive_cmd (drive_cmd),
    .gate_low  (gate_low),
    .pu_en     (pu_en),
    .pd_en     (pd_en),
    .clamp_en  (clamp_en)
);

// File: tb/miller_clamp_ctrl_test.sv
// Directed bench for miller_clamp_ctrl, one task per scenario.
// Inputs change and outputs are sampled 5 ns after each rising edge.
module miller_clamp_ctrl_test;

    localparam int DEAD = 1;
    localparam int FILT = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic drive_cmd = 1'b0;
    logic gate_low = 1'b0;
    logic pu_en, pd_en, clamp_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    miller_clamp_ctrl #(.DEAD_CYCLES(DEAD), .FILT_CYCLES(FILT)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .drive_cmd (drive_cmd),
        .gate_low  (gate_low),
        .pu_en     (pu_en),
        .pd_en     (pd_en),
        .clamp_en  (clamp_en)
    );

    // Advance n rising edges and settle away from the edge.
    task automatic tick(input int n = 1);
        repeat (n) @(posedge clk);
        #5;
    endtask

    // Compare {pu, pd, clamp} with the expected value.
    task automatic chk(input string req, input logic [2:0] exp);
        checks++;
        if ({pu_en, pd_en, clamp_en} !== exp) begin
            failures++;
            $display("FAIL %s: {pu,pd,clamp} actual=%b expected=%b at %0t",
                     req, {pu_en, pd_en, clamp_en}, exp, $time);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; drive_cmd = 1'b1; gate_low = 1'b1;
        tick(2);
        chk("R1 in reset", 3'b010);
        drive_cmd = 1'b0; gate_low = 1'b0;
        tick();
        rst_n = 1'b1;
        chk("R1 after reset", 3'b010);
    endtask

    task automatic t_turn_on();
        drive_cmd = 1'b1;
        tick();
        chk("R5 gap before pull-up", 3'b000);
        tick(DEAD);
        chk("R2 pull-up on", 3'b100);
        tick(3);
        chk("R2 pull-up held", 3'b100);
    endtask

    task automatic t_ignore_cmp();
        for (int i = 0; i < 6; i++) begin
            gate_low = i[0];
            tick();
            chk("R10 comparator ignored while on", 3'b100);
        end
        gate_low = 1'b0;
    endtask

    task automatic t_turn_off();
        drive_cmd = 1'b0;
        tick();
        chk("R3 pull-up off, gap", 3'b000);
        tick(DEAD);
        chk("R3 main pull-down on", 3'b010);
        tick();
        chk("R6 no clamp above threshold", 3'b010);
    endtask

    task automatic t_engage();
        gate_low = 1'b1;
        tick();
        chk("R6 clamp engaged", 3'b011);
    endtask

    task automatic t_short_excursion();
        gate_low = 1'b0;
        for (int i = 0; i < FILT - 1; i++) begin
            tick();
            chk("R7 clamp held in excursion", 3'b011);
        end
        gate_low = 1'b1;
        tick();
        chk("R7 clamp held after excursion", 3'b011);
        gate_low = 1'b0;
        tick(FILT - 1);
        chk("R7 count restarted", 3'b011);
        gate_low = 1'b1;
        tick();
    endtask

    task automatic t_release();
        gate_low = 1'b0;
        tick(FILT - 1);
        chk("R8 still clamped one short", 3'b011);
        tick();
        chk("R8 clamp released, pull-down kept", 3'b010);
        tick(2);
        chk("R8 stays released", 3'b010);
        gate_low = 1'b1;
        tick();
        chk("R8 clamp re-engaged", 3'b011);
    endtask

    task automatic t_cmd_release();
        drive_cmd = 1'b1;
        tick();
        chk("R9 clamp and pull-down off together", 3'b000);
        tick(DEAD);
        chk("R9 pull-up after gap", 3'b100);
        drive_cmd = 1'b0; gate_low = 1'b0;
        tick(DEAD + 1);
        chk("R3 back to pull-down", 3'b010);
        drive_cmd = 1'b1; gate_low = 1'b1;
        tick();
        chk("R6 no clamp with command high", 3'b000);
        drive_cmd = 1'b0;
        tick(DEAD);
        chk("R2 gap completes to pull-up", 3'b100);
        tick(DEAD + 1);
        chk("R3 returns to pull-down", 3'b010);
        tick();
        chk("R6 clamp after pull-down settles", 3'b011);
    endtask

    initial begin
        #1;
        t_reset();
        t_turn_on();
        t_ignore_cmp();
        t_turn_off();
        t_engage();
        t_short_excursion();
        t_release();
        t_cmd_release();
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule